// File: doc/BRIEF.md
# Downstream Port Reset and Speed Negotiation Sequencer

This block owns the reset of a single downstream-facing port of a hub. It watches the port's decoded line state to decide when a device has arrived or left, and on a reset command it drives SE0 for a fixed window. While that window runs, it listens for the device's Chirp K. If the chirp is accepted, the block answers with its own sequence of alternating K and J chirps. Once the window closes, it reports the speed that was negotiated and enables the port. It can also drive a timed resume K onto an enabled port.

All timing is counted in a microsecond tick that is supplied from outside, so the block runs from any core clock. Every window is a parameter expressed in ticks: the reset length, the filter on the device chirp, the length of one hub chirp, the quiet SE0 tail, the connect debounce for the awake and the suspended case, the disconnect debounce, and the resume length. Line drive requests go to the transceiver. Analog signalling and packet repeating stay outside.

Top module: `port_reset_seq`

## Requirements
- R1: After reset, all drive requests, `connected`, `port_enabled`, `reset_done` and `speed` are 0.
- R2: `line_state` uses these codes: 00 SE0, 01 J, 10 K, 11 device absent. While detached, the port becomes connected once J or K has been held for CONN_US consecutive ticks, or SUSP_CONN_US ticks when `hub_suspended` is 1. Any other code restarts the count.
- R3: In any attached state, code 11 held for DISC_US consecutive ticks detaches the port. A shorter run has no effect.
- R4: A reset command is accepted only when the port is attached, enabled or resuming. It drives SE0 and holds `port_enabled` low, and the whole reset window lasts RST_US ticks. A reset command given while a reset is already running is ignored.
- R5: The device Chirp K is accepted only when K is seen for CHIRP_FILT_US consecutive ticks during the reset window. A shorter K is ignored.
- R6: After a Chirp K is accepted, the hub's first chirp (a K) starts on the cycle after the line leaves K. This is well inside 100 µs.
- R7: Hub chirps alternate K and J, and each lasts CHIRP_LEN_US ticks. A new chirp starts only if it can end at least TAIL_US ticks before the reset window ends. SE0 fills the rest of the window, so the tail is between 100 and 500 µs.
- R8: When the reset window ends, `port_enabled` rises and `reset_done` pulses for one cycle. `speed` is 01 if `dev_low_speed` is set, 10 if hub chirps were sent, and 00 otherwise.
- R9: A low-speed device never receives chirps, even if K appears on the line.
- R10: A disconnect during reset aborts the sequence: no `reset_done`, and `port_enabled` stays 0.
- R11: `resume_cmd` on an enabled port drives K for RESUME_US ticks while the port stays enabled. It is ignored in any other state. A reset command given in the same cycle wins.
- R12: Every window advances only on cycles where `us_tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst_n | input | 1 | active-low synchronous reset |
| us_tick | input | 1 | one-cycle microsecond strobe |
| reset_cmd | input | 1 | port reset request strobe |
| resume_cmd | input | 1 | resume request strobe |
| line_state | input | 2 | decoded line: 00 SE0, 01 J, 10 K, 11 absent |
| dev_low_speed | input | 1 | attached device is low speed |
| hub_suspended | input | 1 | hub is suspended (longer connect debounce) |
| drive_se0 | output | 1 | request to drive SE0 |
| drive_k | output | 1 | request to drive K |
| drive_j | output | 1 | request to drive J |
| connected | output | 1 | a device is attached |
| port_enabled | output | 1 | port enabled after reset |
| speed | output | 2 | 00 full, 01 low, 10 high |
| reset_done | output | 1 | one-cycle pulse at the end of reset |

## Verification
Every output comes either from a register or from a decode of state. The result of an input sampled at one rising edge is therefore visible on the following falling edge, where the reference model and the design are compared every cycle.

Window lengths are measured as run lengths of the drive outputs, in cycles:
- the SE0 window and the resume K must last exactly their tick count when the tick is present every cycle;
- the first hub chirp must start one cycle after the bench releases K;
- the SE0 tail must land between 200 and 249 cycles.

// File: rtl/port_reset_seq.sv
module port_reset_seq #(
  parameter int RST_US        = 10000,
  parameter int CHIRP_FILT_US = 3,
  parameter int CHIRP_LEN_US  = 50,
  parameter int TAIL_US       = 200,
  parameter int CONN_US       = 3,
  parameter int SUSP_CONN_US  = 100,
  parameter int DISC_US       = 2,
  parameter int RESUME_US     = 20000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       us_tick,
  input  logic       reset_cmd,
  input  logic       resume_cmd,
  input  logic [1:0] line_state,
  input  logic       dev_low_speed,
  input  logic       hub_suspended,
  output logic       drive_se0,
  output logic       drive_k,
  output logic       drive_j,
  output logic       connected,
  output logic       port_enabled,
  output logic [1:0] speed,
  output logic       reset_done
);

  localparam int MAXT  = (RESUME_US > RST_US) ? RESUME_US : RST_US;
  localparam int TW    = $clog2(MAXT + 1);
  localparam int MAXS  = (CHIRP_LEN_US > CHIRP_FILT_US) ? CHIRP_LEN_US : CHIRP_FILT_US;
  localparam int SW    = $clog2(MAXS + 1);
  localparam int MAXC  = (SUSP_CONN_US > CONN_US) ? SUSP_CONN_US : CONN_US;
  localparam int MAXD  = (MAXC > DISC_US) ? MAXC : DISC_US;
  localparam int DW    = $clog2(MAXD + 1);

  localparam logic [TW-1:0] T_RST_END   = TW'(RST_US - 1);
  localparam logic [TW-1:0] T_RSM_END   = TW'(RESUME_US - 1);
  localparam logic [TW-1:0] T_CHIRP_STOP = TW'(RST_US - TAIL_US - CHIRP_LEN_US);
  localparam logic [SW-1:0] S_FILT_END  = SW'(CHIRP_FILT_US - 1);
  localparam logic [SW-1:0] S_CHIRP_END = SW'(CHIRP_LEN_US - 1);

  localparam logic [1:0] LN_J    = 2'b01;
  localparam logic [1:0] LN_K    = 2'b10;
  localparam logic [1:0] LN_GONE = 2'b11;

  typedef enum logic [2:0] {
    ST_DET, ST_ATT, ST_RST, ST_DKEND, ST_CHIRP, ST_TAIL, ST_EN, ST_RSM
  } st_t;

  st_t           state;
  logic [TW-1:0] tcnt;
  logic [SW-1:0] sub;
  logic [DW-1:0] deb;
  logic          chirp_k;
  logic          hs;

  logic          in_reset, deb_cond, deb_hit, rst_end, line_k;
  logic [DW-1:0] deb_lim;

  assign line_k   = (line_state == LN_K);
  assign in_reset = (state == ST_RST) || (state == ST_DKEND) ||
                    (state == ST_CHIRP) || (state == ST_TAIL);
  assign deb_cond = (state == ST_DET) ? (line_state == LN_J || line_k)
                                      : (line_state == LN_GONE);
  assign deb_lim  = (state != ST_DET) ? DW'(DISC_US - 1) :
                    hub_suspended     ? DW'(SUSP_CONN_US - 1) : DW'(CONN_US - 1);
  assign deb_hit  = deb_cond && us_tick && (deb == deb_lim);
  assign rst_end  = in_reset && us_tick && (tcnt == T_RST_END);

  assign drive_se0 = (state == ST_RST) || (state == ST_DKEND) || (state == ST_TAIL);
  assign drive_k   = ((state == ST_CHIRP) && chirp_k) || (state == ST_RSM);
  assign drive_j   = (state == ST_CHIRP) && !chirp_k;
  assign connected = (state != ST_DET);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_DET;
      tcnt         <= '0;
      sub          <= '0;
      deb          <= '0;
      chirp_k      <= 1'b0;
      hs           <= 1'b0;
      port_enabled <= 1'b0;
      speed        <= 2'b00;
      reset_done   <= 1'b0;
    end else begin
      reset_done <= 1'b0;
      if (!deb_cond)    deb <= '0;
      else if (us_tick) deb <= deb_hit ? '0 : deb + 1'b1;

      if (state != ST_DET && deb_hit) begin
        state        <= ST_DET;
        port_enabled <= 1'b0;
        speed        <= 2'b00;
        hs           <= 1'b0;
      end else if (state == ST_DET) begin
        if (deb_hit) state <= ST_ATT;
      end else if (reset_cmd && (state == ST_ATT || state == ST_EN || state == ST_RSM)) begin
        state        <= ST_RST;
        tcnt         <= '0;
        sub          <= '0;
        hs           <= 1'b0;
        port_enabled <= 1'b0;
        speed        <= 2'b00;
      end else if (rst_end) begin
        state        <= ST_EN;
        port_enabled <= 1'b1;
        reset_done   <= 1'b1;
        speed        <= dev_low_speed ? 2'b01 : (hs ? 2'b10 : 2'b00);
      end else begin
        if (in_reset && us_tick) tcnt <= tcnt + 1'b1;
        case (state)
          ST_EN: if (resume_cmd) begin
            state <= ST_RSM;
            tcnt  <= '0;
          end
          ST_RSM: if (us_tick) begin
            if (tcnt == T_RSM_END) state <= ST_EN;
            else                   tcnt  <= tcnt + 1'b1;
          end
          ST_RST: begin
            if (line_k && !dev_low_speed) begin
              if (us_tick) begin
                if (sub == S_FILT_END) begin
                  state <= ST_DKEND;
                  sub   <= '0;
                end else sub <= sub + 1'b1;
              end
            end else sub <= '0;
          end
          ST_DKEND: if (!line_k) begin
            if (tcnt < T_CHIRP_STOP) begin
              state   <= ST_CHIRP;
              chirp_k <= 1'b1;
              hs      <= 1'b1;
              sub     <= '0;
            end else state <= ST_TAIL;
          end
          ST_CHIRP: if (us_tick) begin
            if (sub == S_CHIRP_END) begin
              sub <= '0;
              if (tcnt < T_CHIRP_STOP) chirp_k <= !chirp_k;
              else                     state   <= ST_TAIL;
            end else sub <= sub + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  a_r1_drive_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drive_se0, drive_k, drive_j}));
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reset_done |=> !reset_done);
  a_r8_done_enables: assert property (@(posedge clk) disable iff (!rst_n)
    reset_done |-> port_enabled && !drive_se0);
  a_r4_no_enable_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    drive_se0 |-> !port_enabled);
  a_r3_detached_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !connected |-> !port_enabled && speed == 2'b00 && !drive_se0 && !drive_k && !drive_j);
  a_r7_chirp_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_j) |-> $past(drive_k));
  a_r10_no_done_on_abort: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(connected) |-> !reset_done);
  a_r11_resume_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_k && port_enabled) |=> (port_enabled || drive_se0 || !connected));

endmodule

// File: tb/port_reset_seq_tb_top.sv
module port_reset_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RST_US = 10000, FILT = 3, CLEN = 50, TAIL = 200;
  localparam int CONN = 3, SCONN = 100, DISC = 2, RSM = 20000;
  localparam int WATCHDOG = 190000;

  logic clk = 0, rst_n = 0, us_tick = 1, reset_cmd = 0, resume_cmd = 0;
  logic [1:0] line_state = 2'b00;
  logic dev_low_speed = 0, hub_suspended = 0;
  logic drive_se0, drive_k, drive_j, connected, port_enabled, reset_done;
  logic [1:0] speed;

  always #(CLK_PERIOD/2) clk = ~clk;

  port_reset_seq dut_i (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .reset_cmd(reset_cmd),
    .resume_cmd(resume_cmd), .line_state(line_state), .dev_low_speed(dev_low_speed),
    .hub_suspended(hub_suspended), .drive_se0(drive_se0), .drive_k(drive_k),
    .drive_j(drive_j), .connected(connected), .port_enabled(port_enabled),
    .speed(speed), .reset_done(reset_done));

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit tick_gate = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model: phases 0 detached,1 attached,2 reset,3 wait K end,4 chirping,5 tail,6 enabled,7 resume
  int  m_phase = 0, m_time = 0, m_run = 0, m_stable = 0, m_lim = 0, m_pre = 0;
  bit  m_k = 0, m_hs = 0, m_en = 0, m_done = 0, m_cond = 0, m_hit = 0, m_rend = 0;
  int  m_spd = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_phase = 0; m_time = 0; m_run = 0; m_stable = 0;
      m_k = 0; m_hs = 0; m_en = 0; m_done = 0; m_spd = 0;
    end else begin
      m_done = 0;
      m_cond = (m_phase == 0) ? (line_state == 2'b01 || line_state == 2'b10) : (line_state == 2'b11);
      m_lim  = (m_phase != 0) ? DISC : (hub_suspended ? SCONN : CONN);
      m_hit  = 0;
      if (!m_cond) m_stable = 0;
      else if (us_tick) begin
        m_stable++;
        if (m_stable == m_lim) begin m_hit = 1; m_stable = 0; end
      end
      m_rend = (m_phase >= 2 && m_phase <= 5) && us_tick && (m_time + 1 == RST_US);
      if (m_phase != 0 && m_hit) begin
        m_phase = 0; m_en = 0; m_spd = 0; m_hs = 0;
      end else if (m_phase == 0) begin
        if (m_hit) m_phase = 1;
      end else if (reset_cmd && (m_phase == 1 || m_phase == 6 || m_phase == 7)) begin
        m_phase = 2; m_time = 0; m_run = 0; m_hs = 0; m_en = 0; m_spd = 0;
      end else if (m_rend) begin
        m_phase = 6; m_en = 1; m_done = 1;
        m_spd = dev_low_speed ? 1 : (m_hs ? 2 : 0);
      end else begin
        m_pre = m_time;
        if (m_phase >= 2 && m_phase <= 5 && us_tick) m_time++;
        if (m_phase == 6) begin
          if (resume_cmd) begin m_phase = 7; m_time = 0; end
        end else if (m_phase == 7) begin
          if (us_tick) begin
            if (m_time + 1 == RSM) m_phase = 6; else m_time++;
          end
        end else if (m_phase == 2) begin
          if (line_state == 2'b10 && !dev_low_speed) begin
            if (us_tick) begin
              m_run++;
              if (m_run == FILT) begin m_phase = 3; m_run = 0; end
            end
          end else m_run = 0;
        end else if (m_phase == 3) begin
          if (line_state != 2'b10) begin
            if (m_pre < RST_US - TAIL - CLEN) begin m_phase = 4; m_k = 1; m_hs = 1; m_run = 0; end
            else m_phase = 5;
          end
        end else if (m_phase == 4) begin
          if (us_tick) begin
            m_run++;
            if (m_run == CLEN) begin
              m_run = 0;
              if (m_pre < RST_US - TAIL - CLEN) m_k = !m_k; else m_phase = 5;
            end
          end
        end
      end
    end
  end

  // per-cycle comparison and run-length monitor
  int se0_run = 0, last_se0 = 0, ch_run = 0, ch_prev = 0, ch_min = 0, ch_max = 0;
  int n_chirps = 0, first_ch_cyc = 0, rsm_run = 0, last_rsm = 0, done_cnt = 0;
  bit p_se0 = 0;

  always @(negedge clk) begin
    int cur;
    if (rst_n) begin
      chk(drive_se0 === (m_phase == 2 || m_phase == 3 || m_phase == 5), "R4 drive_se0", drive_se0, 0);
      chk(drive_k === ((m_phase == 4 && m_k) || m_phase == 7), "R7 drive_k", drive_k, 0);
      chk(drive_j === (m_phase == 4 && !m_k), "R7 drive_j", drive_j, 0);
      chk(connected === (m_phase != 0), "R2 connected", connected, m_phase != 0);
      chk(port_enabled === m_en, "R8 port_enabled", port_enabled, m_en);
      chk(speed === 2'(m_spd), "R8 speed", speed, m_spd);
      chk(reset_done === m_done, "R8 reset_done", reset_done, m_done);
    end
    if (reset_done) done_cnt++;
    if (drive_se0) se0_run++;
    else if (p_se0) begin last_se0 = se0_run; se0_run = 0; end
    p_se0 = drive_se0;
    cur = (!port_enabled && drive_k) ? 1 : (drive_j ? 2 : 0);
    if (cur != ch_prev && ch_prev != 0) begin
      if (ch_min == 0 || ch_run < ch_min) ch_min = ch_run;
      if (ch_run > ch_max) ch_max = ch_run;
      ch_run = 0;
    end
    if (cur != 0) begin
      if (ch_prev == 0 && n_chirps == 0) first_ch_cyc = cyc;
      if (cur != ch_prev) n_chirps++;
      ch_run++;
    end
    ch_prev = cur;
    if (drive_k && port_enabled) rsm_run++;
    else if (rsm_run != 0) begin last_rsm = rsm_run; rsm_run = 0; end
  end

  always @(negedge clk) us_tick <= tick_gate ? !us_tick : 1'b1;

  always @(posedge clk) if (cyc > WATCHDOG) begin
    n_fail++;
    $display("FAIL R4 watchdog expired actual=%0d expected=%0d", cyc, WATCHDOG);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_reset();
    @(negedge clk); reset_cmd = 1; @(negedge clk); reset_cmd = 0;
  endtask

  task automatic clear_meas();
    ch_min = 0; ch_max = 0; n_chirps = 0; first_ch_cyc = 0; done_cnt = 0;
  endtask

  task automatic wait_done(input int maxc);
    for (int i = 0; i < maxc && !reset_done; i++) @(negedge clk);
    @(negedge clk);
  endtask

  int rel_cyc;

  initial begin
    step(4);
    chk(!drive_se0 && !drive_k && !drive_j && !connected && !port_enabled && speed == 0 && !reset_done,
        "R1 reset state", {drive_se0, drive_k, drive_j, connected, port_enabled}, 0);
    rst_n = 1;
    step(2);
    // R2 interrupted connect
    line_state = 2'b01; step(2); line_state = 2'b00; step(3);
    chk(!connected, "R2 short attach ignored", connected, 0);
    line_state = 2'b01; step(5);
    chk(connected, "R2 attach after debounce", connected, 1);
    // R11 resume ignored when not enabled
    @(negedge clk); resume_cmd = 1; @(negedge clk); resume_cmd = 0; step(2);
    chk(!drive_k, "R11 resume ignored when attached", drive_k, 0);
    // R4/R8 full-speed reset, second command ignored
    clear_meas(); line_state = 2'b00; pulse_reset();
    step(5000); pulse_reset();
    wait_done(12000);
    chk(last_se0 == RST_US, "R4 reset window length", last_se0, RST_US);
    chk(port_enabled && speed == 2'b00, "R8 full speed result", speed, 0);
    chk(done_cnt == 1, "R8 single done pulse", done_cnt, 1);
    line_state = 2'b01;
    // R5/R6/R7 high-speed handshake
    clear_meas(); pulse_reset(); line_state = 2'b00; step(100);
    line_state = 2'b10; step(2); line_state = 2'b00; step(50);
    chk(drive_se0 && !drive_k, "R5 short K ignored", drive_k, 0);
    line_state = 2'b10; step(1000); line_state = 2'b00; rel_cyc = cyc;
    wait_done(12000);
    chk(first_ch_cyc - rel_cyc == 1, "R6 first chirp delay", first_ch_cyc - rel_cyc, 1);
    chk(ch_min == CLEN && ch_max == CLEN, "R7 chirp length", ch_min, CLEN);
    chk(last_se0 >= TAIL && last_se0 < TAIL + CLEN, "R7 tail length", last_se0, TAIL);
    chk(speed == 2'b10, "R8 high speed result", speed, 2);
    // R11 resume from enabled
    line_state = 2'b01;
    @(negedge clk); resume_cmd = 1; @(negedge clk); resume_cmd = 0;
    step(RSM + 5);
    chk(last_rsm == RSM, "R11 resume length", last_rsm, RSM);
    chk(port_enabled, "R11 enabled after resume", port_enabled, 1);
    // R11 priority, R9 low speed, R12 gated tick
    clear_meas(); dev_low_speed = 1; tick_gate = 1;
    @(negedge clk); reset_cmd = 1; resume_cmd = 1; @(negedge clk); reset_cmd = 0; resume_cmd = 0;
    chk(drive_se0, "R11 reset wins over resume", drive_se0, 1);
    line_state = 2'b00; step(200); line_state = 2'b10; step(1000); line_state = 2'b00;
    wait_done(24000);
    chk(n_chirps == 0, "R9 no chirps for low speed", n_chirps, 0);
    chk(speed == 2'b01, "R8 low speed result", speed, 1);
    chk(last_se0 >= 2*RST_US - 2 && last_se0 <= 2*RST_US + 2, "R12 window on ticks", last_se0, 2*RST_US);
    tick_gate = 0; dev_low_speed = 0;
    // R3/R10 disconnect during reset
    clear_meas(); pulse_reset(); step(300);
    line_state = 2'b11; step(1); line_state = 2'b00; step(3);
    chk(drive_se0 && connected, "R3 short detach ignored", connected, 1);
    line_state = 2'b11; step(5);
    chk(!connected && !drive_se0 && !port_enabled, "R10 abort on disconnect", connected, 0);
    step(20);
    chk(done_cnt == 0, "R10 no done after abort", done_cnt, 0);
    // R2 suspended connect window
    hub_suspended = 1; line_state = 2'b01; step(60);
    chk(!connected, "R2 suspended debounce not yet", connected, 0);
    step(45);
    chk(connected, "R2 suspended debounce done", connected, 1);
    hub_suspended = 0; line_state = 2'b11; step(4);
    chk(!connected, "R3 detach from attached", connected, 0);
    step(5);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule